// File: doc/BRIEF.md
# Flash-Clearable 1K x 4 Synchronous Memory

This block is a cycle-level model of a 1024-word by 4-bit static memory with separate 4-bit write-data and read-data ports. It is controlled by four active-low pins: chip select, write enable, output enable and a wipe request. Each clock cycle carries exactly one operation, either a write, a read or nothing. A read returns its data in the cycle after the clock edge that sampled it. The read-data port comes with a drive-enable flag, so the surrounding logic can model the three-state pins: when the flag is low the port is treated as floating and holds zero.

The wipe request empties the whole array in two cycles without stepping through the addresses. The first edge records the request and raises a busy flag. The second edge drops every per-word "written" marker at once. A word whose marker is down reads as zero no matter what its storage cells hold. Reads sampled while a wipe is requested or in progress return zero. Writes sampled in that window are discarded.

The memory sits among ordinary control pins with no flow control. An operation is accepted in the cycle its pins are sampled, and there is no back-pressure.

Top module: `fcram_top`

## Requirements
- R1: After reset, `rd_drive` is 0, `rd_data` is 0 and `wipe_busy` is 0, and every word reads as zero until it is written.
- R2: A write is sampled at a rising edge when `sel_n`=0, `wr_n`=0 and `wipe_n`=1 with `wipe_busy`=0. It stores `wr_data` at `addr`, and in the following cycle `rd_drive` is 0.
- R3: A read is sampled at a rising edge when `sel_n`=0, `oe_n`=0 and `wr_n`=1. In the following cycle `rd_drive` is 1 and `rd_data` holds the word at `addr`.
- R4: After an edge that samples no read (`sel_n`=1, `oe_n`=1, or `wr_n`=0), the next cycle has `rd_drive`=0 and `rd_data`=0.
- R5: A word that has not been written since reset or since the last wipe reads as zero.
- R6: `wipe_n`=0 sampled at an edge raises `wipe_busy` for the next cycle. At the following edge all words become zero. `wipe_busy` falls one cycle after `wipe_n`=1 is sampled.
- R7: A write sampled in the same edge as `wipe_n`=0, or while `wipe_busy`=1, is ignored, and the word still reads as zero afterwards.
- R8: A read sampled while `wipe_n`=0 or `wipe_busy`=1 returns zero with `rd_drive`=1.
- R9: A read sampled in the cycle right after a write to the same address returns the new data. A later write to the same address replaces the earlier data.
- R10: All 10 address bits select distinct words, including the lowest (0) and highest (1023) address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| wipe_n | input | 1 | Whole-array clear request, active low |
| addr | input | 10 | Word address |
| wr_data | input | 4 | Data to store |
| rd_data | output | 4 | Read data, zero while not driven |
| rd_drive | output | 1 | High when the read-data pins would be driven |
| wipe_busy | output | 1 | High while a clear is in progress |

## Verification
The properties assume that every control pin is at a known level at each rising edge and that `addr` and `wr_data` are settled when the edge samples them. They also assume that reset is released only once and is not pulsed again during operation. The bench changes every input on the falling edge only, never leaves a pin undriven, and holds `rst_n` high after the initial release. Its random traffic keeps wipe requests rare and confines addresses to a small pool plus both extremes, so that reads often hit written words as well as empty ones.

// File: rtl/fcram_pkg.sv
package fcram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } fcram_op_e;

  function automatic fcram_op_e fcram_decode_op(input logic sel_n, input logic wr_n,
                                                 input logic oe_n);
    if (sel_n) return OP_NONE;
    if (!wr_n) return OP_WRITE;
    if (!oe_n) return OP_READ;
    return OP_NONE;
  endfunction
endpackage

// File: rtl/fcram_decode.sv
module fcram_decode
  import fcram_pkg::*;
(
  input  logic sel_n,
  input  logic wr_n,
  input  logic oe_n,
  input  logic wipe_n,
  input  logic wipe_busy,
  output logic rd_en,
  output logic wr_en,
  output logic rd_zero
);
  fcram_op_e op;

  always_comb begin
    op      = fcram_decode_op(sel_n, wr_n, oe_n);
    // a pending or fresh clear forces zero reads and swallows writes
    rd_zero = !wipe_n || wipe_busy;
    rd_en   = (op == OP_READ);
    wr_en   = (op == OP_WRITE) && !rd_zero;
  end
endmodule

// File: rtl/fcram_clear_ctl.sv
module fcram_clear_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wipe_n,
  output logic wipe_busy,
  output logic wipe_apply
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= !wipe_n;
  end

  assign wipe_busy  = pend_q;
  assign wipe_apply = pend_q;
endmodule

// File: rtl/fcram_store.sv
module fcram_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              rd_zero,
  input  logic              wipe_apply,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DEPTH-1:0]  written;

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= wr_data;
  end

  for (genvar w = 0; w < DEPTH; w++) begin : g_mark
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        written[w] <= 1'b0;
      else if (wipe_apply)
        written[w] <= 1'b0;
      else if (wr_en && (addr == ADDR_W'(w)))
        written[w] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_q <= '0;
    else if (rd_en && !rd_zero && written[addr])
      rd_q <= cells[addr];
    else
      rd_q <= '0;
  end
endmodule

// File: rtl/fcram_top.sv
module fcram_top #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic              wipe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive,
  output logic              wipe_busy
);
  logic rd_en;
  logic wr_en;
  logic rd_zero;
  logic wipe_apply;
  logic drive_q;

  fcram_clear_ctl u_clr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wipe_n     (wipe_n),
    .wipe_busy  (wipe_busy),
    .wipe_apply (wipe_apply)
  );

  fcram_decode u_dec (
    .sel_n     (sel_n),
    .wr_n      (wr_n),
    .oe_n      (oe_n),
    .wipe_n    (wipe_n),
    .wipe_busy (wipe_busy),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .rd_zero   (rd_zero)
  );

  fcram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rd_zero    (rd_zero),
    .wipe_apply (wipe_apply),
    .addr       (addr),
    .wr_data    (wr_data),
    .rd_q       (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_q <= 1'b0;
    else        drive_q <= rd_en;
  end

  assign rd_drive = drive_q;
endmodule

// File: rtl/fcram_chk.sv
module fcram_chk #(
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              wr_n,
  input logic              oe_n,
  input logic              wipe_n,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_drive,
  input logic              wipe_busy
);
  logic is_rd;
  logic is_wr;
  assign is_rd = !sel_n && !oe_n && wr_n;
  assign is_wr = !sel_n && !wr_n;

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!rd_drive && rd_data == '0 && !wipe_busy); // R1
    end
  end

  AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |=> !rd_drive); // R2
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> rd_drive); // R3
  AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |=> !rd_drive); // R4
  AST_FLOAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_drive |-> rd_data == '0); // R4
  AST_WIPE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !wipe_n |=> wipe_busy); // R6
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_n |=> !wipe_busy); // R6
  AST_WIPE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && (!wipe_n || wipe_busy)) |=> (rd_drive && rd_data == '0)); // R8
endmodule

bind fcram_top fcram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_n     (sel_n),
  .wr_n      (wr_n),
  .oe_n      (oe_n),
  .wipe_n    (wipe_n),
  .rd_data   (rd_data),
  .rd_drive  (rd_drive),
  .wipe_busy (wipe_busy)
);

// File: tb/sim_fcram_top.sv
module sim_fcram_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 4;
  localparam int WORDS = 1 << AW;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic wr_n = 1'b1;
  logic oe_n = 1'b1;
  logic wipe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_drive;
  logic wipe_busy;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  logic [DW-1:0] model [WORDS];
  bit pend_m = 0;
  logic [DW-1:0] exp_data;
  bit exp_drive;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcram_top u0 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .oe_n(oe_n),
    .wipe_n(wipe_n), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .rd_drive(rd_drive), .wipe_busy(wipe_busy)
  );

  function automatic bit is_read(input bit s, input bit w, input bit o);
    return !s && !o && w;
  endfunction

  function automatic bit is_write(input bit s, input bit w);
    return !s && !w;
  endfunction

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a, input bit zero);
    return zero ? '0 : model[a];
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // starts and ends at a falling edge
  task automatic step(input bit s, input bit w, input bit o, input bit c,
                      input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    bit rd;
    bit wr;
    bit zero;
    sel_n = s; wr_n = w; oe_n = o; wipe_n = c; addr = a; wr_data = d;
    @(posedge clk);
    rd   = is_read(s, w, o);
    wr   = is_write(s, w);
    zero = !c || pend_m;
    if (wr && !zero) model[a] = d;
    exp_drive = rd;
    exp_data  = rd ? model_read(a, zero) : '0;
    if (pend_m) for (int i = 0; i < WORDS; i++) model[i] = '0;
    pend_m = !c;
    @(negedge clk);
    check(tag, "rd_drive", int'(rd_drive), int'(exp_drive));
    check(tag, "rd_data", int'(rd_data), int'(exp_data));
    check("R6", "wipe_busy", int'(wipe_busy), int'(pend_m));
  endtask

  task automatic wr_op(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    step(0, 0, 1, 1, a, d, tag);
  endtask

  task automatic rd_op(input logic [AW-1:0] a, input string tag);
    step(0, 1, 0, 1, a, '0, tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check("R1", "rd_drive in reset", int'(rd_drive), 0);
    check("R1", "rd_data in reset", int'(rd_data), 0);
    check("R1", "wipe_busy in reset", int'(wipe_busy), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R5: fresh words read zero
    rd_op(10'd0, "R1");
    rd_op(10'd517, "R5");
    rd_op(10'd1023, "R5");

    // R2 / R3 / R10: extremes of the address range
    wr_op(10'd0, 4'h5, "R2");
    wr_op(10'd1023, 4'hA, "R10");
    wr_op(10'd512, 4'h3, "R10");
    rd_op(10'd0, "R10");
    rd_op(10'd1023, "R10");
    rd_op(10'd512, "R3");
    rd_op(10'd1, "R5");

    // R9: write then immediate read, then overwrite
    wr_op(10'd77, 4'hC, "R9");
    rd_op(10'd77, "R9");
    wr_op(10'd77, 4'h9, "R9");
    rd_op(10'd77, "R9");

    // R4: select high, output enable high
    step(1, 1, 0, 1, 10'd77, '0, "R4");
    step(0, 1, 1, 1, 10'd77, '0, "R4");
    step(1, 0, 0, 1, 10'd77, 4'hF, "R4");
    rd_op(10'd77, "R4");

    // R6 / R8: single-cycle wipe, read during busy
    step(0, 1, 0, 0, 10'd77, '0, "R8");
    rd_op(10'd1023, "R8");
    rd_op(10'd77, "R6");
    rd_op(10'd0, "R6");

    // R7: write together with wipe, and write during busy
    wr_op(10'd200, 4'h6, "R7");
    step(0, 0, 1, 0, 10'd201, 4'h7, "R7");
    wr_op(10'd202, 4'h8, "R7");
    rd_op(10'd200, "R7");
    rd_op(10'd201, "R7");
    rd_op(10'd202, "R7");
    wr_op(10'd203, 4'h2, "R2");
    rd_op(10'd203, "R2");

    // R6: wipe held for several cycles
    wr_op(10'd300, 4'hE, "R2");
    repeat (3) step(1, 1, 1, 0, 10'd0, '0, "R6");
    rd_op(10'd300, "R8");
    rd_op(10'd300, "R6");

    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic [AW-1:0] a;
      int pick;
      pick = $urandom_range(0, 9);
      a = (pick == 0) ? 10'd0 : (pick == 1) ? 10'd1023 : AW'($urandom_range(0, 15) * 37);
      step(1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 4) == 0), !($urandom_range(0, 60) == 0),
           a, DW'($urandom), "R3");
    end

    for (int i = 0; i < 16; i++) rd_op(AW'(i * 37), "R9");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule